// File: doc/BRIEF.md
# Lightweight Feistel Encryption Core

This block encrypts one plaintext block at a time with a small AND/rotate Feistel cipher. A single parameter `N` sets the word width to 16, 24 or 32 bits. That gives block/key sizes of 32/64, 48/96 or 64/128 bits. The core works through one round per clock.

Round keys are never stored. A four-word key state advances next to the data path. It reuses the data round's nonlinear mixing step, fed with a fixed constant whose low bit is replaced by one bit per round from an internal LFSR.

A caller pulses `start` with a plaintext and master key. After the fixed number of rounds, the ciphertext appears on `ct` together with a one-clock `done` pulse, and `ct` holds that value until the next completion.

Top module: `lwc_enc_core`

## Requirements
- R1: With N=16, run for 32 rounds: key `64'h1918111009080100` with plaintext `32'h65656877` yields ciphertext `32'h770d2c76`. The plaintext upper half is the left word l and the lower half the right word r. Each round sets l' = r ^ f(l) ^ rk and r' = l, where f(x) = (x & rotl(x,5)) ^ rotl(x,1).
- R2: With N=24 the core runs 36 rounds and matches an independent model of R1 and R4 for any 48-bit plaintext and 96-bit key.
- R3: With N=32 the core runs 44 rounds and matches the model for any 64-bit plaintext and 128-bit key. The constant bit comes from a 6-bit all-ones-seeded register that shifts right, with new top bit s[0]^s[1].
- R4: The key input is packed {t2,t1,t0,k}, with k in the least-significant word, and k is the key used in the first round. Each round updates the key state as follows:
  - the new k is t0, the new t0 is t1 and the new t1 is t2;
  - the new t2 is k ^ f(t0) ^ C ^ z, where C = 2^N-4 and z is the current LFSR bit, placed in bit 0.
- R5: For N of 16 or 24, z is s[0] of a 5-bit register seeded all ones that shifts right with new top bit s[0]^s[2]. `done` is high in exactly the cycle after the clock edge that lies ROUNDS edges after the edge that accepted `start`.
- R6: `done` is never high for two consecutive cycles.
- R7: A `start` raised while an encryption is running is ignored: neither that run's result nor its timing changes, and no extra `done` appears.
- R8: The LFSR is reseeded on every accepted start, so encrypting the same input twice gives the same ciphertext.
- R9: `ct` keeps its value in every cycle in which `done` is low.
- R10: After a synchronous active-high reset, `done` is 0 and `ct` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption (accepted only when idle) |
| pt | input | 2*N | Plaintext {l, r} |
| key | input | 4*N | Master key {t2, t1, t0, k} |
| ct | output | 2*N | Ciphertext {l, r}, held until the next completion |
| done | output | 1 | One-clock pulse when `ct` is updated |

## Verification
The hardest case to reach is a start strobe that arrives while a run is in progress. The bench raises it ten cycles into a run, carrying a different plaintext and key. It then requires the original ciphertext at the original completion cycle, with no second `done`.

The 6-bit LFSR and the longest round count are reached only through the widest configuration. For that reason, three instances with N=16, 24 and 32 run side by side on the same stimulus.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Number of rounds for a given word width.
    function automatic int unsigned rounds_for(int unsigned n);
        case (n)
            16:      return 32;
            24:      return 36;
            default: return 44;
        endcase
    endfunction

    // Length of the round-constant sequence register.
    function automatic int unsigned zlen_for(int unsigned n);
        return (n == 32) ? 6 : 5;
    endfunction

endpackage

// File: rtl/lwc_feistel_step.sv
module lwc_feistel_step #(
    parameter int N = 16
) (
    input  logic [N-1:0] lft,
    input  logic [N-1:0] rgt,
    input  logic [N-1:0] rk,
    output logic [N-1:0] nxt
);
    logic [N-1:0] rot5;
    logic [N-1:0] rot1;

    always_comb begin
        rot5 = {lft[N-6:0], lft[N-1:N-5]};
        rot1 = {lft[N-2:0], lft[N-1]};
        nxt  = (lft & rot5) ^ rot1 ^ rgt ^ rk;
    end
endmodule

// File: rtl/lwc_zgen.sv
module lwc_zgen #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    output logic zbit
);
    localparam int W = int'(lwc_pkg::zlen_for(N));

    logic [W-1:0] st;
    logic         fb;

    generate
        if (W == 6) begin : g_tap6
            assign fb = st[0] ^ st[1];
        end else begin : g_tap5
            assign fb = st[0] ^ st[2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || load) begin
            st <= '1;
        end else if (adv) begin
            st <= {fb, st[W-1:1]};
        end
    end

    assign zbit = st[0];
endmodule

// File: rtl/lwc_keysched.sv
module lwc_keysched #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           adv,
    input  logic [4*N-1:0] key_in,
    output logic [N-1:0]   rk
);
    localparam logic [N-1:0] KCONST = {{(N-2){1'b1}}, 2'b00};

    logic [N-1:0] kw, t0, t1, t2;
    logic [N-1:0] cst, nw;
    logic         z;

    lwc_zgen #(.N(N)) u_zgen (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .adv  (adv),
        .zbit (z)
    );

    assign cst = KCONST | {{(N-1){1'b0}}, z};

    lwc_feistel_step #(.N(N)) u_kstep (
        .lft (t0),
        .rgt (kw),
        .rk  (cst),
        .nxt (nw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            {t2, t1, t0, kw} <= '0;
        end else if (load) begin
            {t2, t1, t0, kw} <= key_in;
        end else if (adv) begin
            kw <= t0;
            t0 <= t1;
            t1 <= t2;
            t2 <= nw;
        end
    end

    assign rk = kw;
endmodule

// File: rtl/lwc_enc_core.sv
module lwc_enc_core #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2*N-1:0] pt,
    input  logic [4*N-1:0] key,
    output logic [2*N-1:0] ct,
    output logic           done
);
    import lwc_pkg::*;

    localparam int ROUNDS = int'(rounds_for(N));
    localparam int CW     = $clog2(ROUNDS);

    run_state_e    st;
    logic [CW-1:0] rnd;
    logic [N-1:0]  l_q, r_q, nl, rk_cur;
    logic          busy, accept, last;

    assign busy   = (st == ST_RUN);
    assign accept = start && !busy;
    assign last   = busy && (rnd == CW'(ROUNDS - 1));

    lwc_keysched #(.N(N)) u_ks (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .adv    (busy),
        .key_in (key),
        .rk     (rk_cur)
    );

    lwc_feistel_step #(.N(N)) u_dstep (
        .lft (l_q),
        .rgt (r_q),
        .rk  (rk_cur),
        .nxt (nl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            rnd  <= '0;
            l_q  <= '0;
            r_q  <= '0;
            ct   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                st         <= ST_RUN;
                rnd        <= '0;
                {l_q, r_q} <= pt;
            end else if (busy) begin
                l_q <= nl;
                r_q <= l_q;
                rnd <= rnd + 1'b1;
                if (last) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                    ct   <= {nl, l_q};
                end
            end
        end
    end
endmodule

// File: rtl/lwc_enc_core_chk.sv
module lwc_enc_core_chk #(
    parameter int N = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic [2*N-1:0]       ct,
    input logic                 busy,
    input logic [$clog2(lwc_pkg::rounds_for(N))-1:0] rnd,
    input logic [N-1:0]         rk,
    input logic [N-1:0]         key_lo
);
    localparam int ROUNDS = int'(lwc_pkg::rounds_for(N));
    localparam int CW     = $clog2(ROUNDS);

    logic       act;
    logic [7:0] tmr;

    // Independent timer of cycles since an accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            tmr <= '0;
        end else if (start && !act) begin
            act <= 1'b1;
            tmr <= '0;
        end else if (act) begin
            tmr <= tmr + 1'b1;
            if (tmr == 8'(ROUNDS - 1)) act <= 1'b0;
        end
    end

    assert_done_time_R5: assert property (@(posedge clk) disable iff (rst)
        (act && tmr == 8'(ROUNDS - 1)) |=> done);

    assert_done_only_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        (act && tmr != 8'(ROUNDS - 1)) |=> !done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && rnd != CW'(ROUNDS - 1)) |=> (busy && rnd == $past(rnd) + 1'b1));

    assert_first_key_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (rk == $past(key_lo)));

    assert_ct_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ct));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!done && ct == '0));
endmodule

bind lwc_enc_core lwc_enc_core_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .ct     (ct),
    .busy   (busy),
    .rnd    (rnd),
    .rk     (rk_cur),
    .key_lo (key[N-1:0])
);

// File: tb/lwc_enc_core_tb_top.sv
module lwc_enc_core_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [63:0]  pt64 = '0;
    logic [127:0] key128 = '0;
    logic [31:0]  ct_a;
    logic [47:0]  ct_b;
    logic [63:0]  ct_c;
    logic         done_a, done_b, done_c;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;

    logic [63:0] exp_q [3][$];
    longint      cyc_q [3][$];
    string       req_q [3][$];
    logic [63:0] last_ct [3];
    logic        prev_done [3];
    int          rnds [3] = '{32, 36, 44};
    int          wid  [3] = '{16, 24, 32};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lwc_enc_core #(.N(16)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .pt(pt64[31:0]), .key(key128[63:0]), .ct(ct_a), .done(done_a));
    lwc_enc_core #(.N(24)) dut_b_i (
        .clk(clk), .rst(rst), .start(start),
        .pt(pt64[47:0]), .key(key128[95:0]), .ct(ct_b), .done(done_b));
    lwc_enc_core #(.N(32)) dut_c_i (
        .clk(clk), .rst(rst), .start(start),
        .pt(pt64), .key(key128), .ct(ct_c), .done(done_c));

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Reference model, written from the requirements.
    function automatic logic [63:0] rotl(logic [63:0] x, int s, int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return ((x << s) | (x >> (n - s))) & m;
    endfunction

    function automatic logic [63:0] fmix(logic [63:0] x, int n);
        return (x & rotl(x, 5, n)) ^ rotl(x, 1, n);
    endfunction

    function automatic logic [63:0] model(int n, logic [127:0] k128, logic [63:0] p);
        logic [63:0] m, l, r, k, t0, t1, t2, tmp, nt, c;
        logic [5:0]  s;
        logic        z, fb;
        int          nr, zw;
        m  = (64'd1 << n) - 64'd1;
        c  = m & ~64'd3;
        l  = (p >> n) & m;
        r  = p & m;
        k  = k128[63:0] & m;
        t0 = 64'(k128 >> n) & m;
        t1 = 64'(k128 >> (2 * n)) & m;
        t2 = 64'(k128 >> (3 * n)) & m;
        zw = (n == 32) ? 6 : 5;
        nr = (n == 16) ? 32 : ((n == 24) ? 36 : 44);
        s  = (zw == 6) ? 6'h3f : 6'h1f;
        for (int i = 0; i < nr; i++) begin
            tmp = l;
            l   = r ^ fmix(l, n) ^ k;
            r   = tmp;
            z   = s[0];
            fb  = (zw == 6) ? (s[0] ^ s[1]) : (s[0] ^ s[2]);
            s   = (s >> 1) | (6'(fb) << (zw - 1));
            nt  = k ^ fmix(t0, n) ^ (c | 64'(z));
            k   = t0;
            t0  = t1;
            t1  = t2;
            t2  = nt;
        end
        return (l << n) | r;
    endfunction

    // Monitor: pops the scoreboard on every completion.
    task automatic mon(int i, logic d, logic [63:0] got);
        if (d) begin
            if (prev_done[i]) chk("R6", "done held two cycles", 64'd1, 64'd0);
            if (exp_q[i].size() == 0) begin
                chk("R7", "unexpected done", 64'd1, 64'd0);
            end else begin
                logic [63:0] e;
                longint      ec;
                string       rq;
                e  = exp_q[i].pop_front();
                ec = cyc_q[i].pop_front();
                rq = req_q[i].pop_front();
                chk(rq, $sformatf("ciphertext n=%0d", wid[i]), got, e);
                chk("R5", $sformatf("done cycle n=%0d", wid[i]), 64'(cyc), 64'(ec));
                last_ct[i] = e;
            end
        end
        prev_done[i] = d;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            mon(0, done_a, 64'(ct_a));
            mon(1, done_b, 64'(ct_b));
            mon(2, done_c, ct_c);
        end
    end

    // Driver: starts all three cores and records the expected results.
    task automatic run_one(logic [63:0] p, logic [127:0] k, string ra, string rb, string rc,
                           logic [63:0] exp_a_override, bit use_override, bit inject);
        @(negedge clk);
        pt64   = p;
        key128 = k;
        start  = 1'b1;
        exp_q[0].push_back(use_override ? exp_a_override : model(16, k, p));
        exp_q[1].push_back(model(24, k, p));
        exp_q[2].push_back(model(32, k, p));
        for (int i = 0; i < 3; i++) cyc_q[i].push_back(cyc + 1 + rnds[i]);
        req_q[0].push_back(ra);
        req_q[1].push_back(rb);
        req_q[2].push_back(rc);
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (9) @(negedge clk);
            pt64   = ~p;
            key128 = ~k;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
        end
        repeat (52) @(negedge clk);
        // R9: ciphertext still holds long after completion.
        chk("R9", "hold n=16", 64'(ct_a), last_ct[0]);
        chk("R9", "hold n=24", 64'(ct_b), last_ct[1]);
        chk("R9", "hold n=32", ct_c, last_ct[2]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            prev_done[i] = 1'b0;
            last_ct[i]   = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state.
        chk("R10", "done after reset", 64'(done_a | done_b | done_c), 64'd0);
        chk("R10", "ct n=16 after reset", 64'(ct_a), 64'd0);
        chk("R10", "ct n=32 after reset", ct_c, 64'd0);

        // R1 and R4: published 32/64 vector.
        run_one(64'h0000_0000_6565_6877, {64'd0, 64'h1918_1110_0908_0100},
                "R1", "R2", "R3", 64'h0000_0000_770d_2c76, 1'b1, 1'b0);
        // R4: model cross-check on the same vector.
        chk("R4", "model vs published vector",
            model(16, {64'd0, 64'h1918_1110_0908_0100}, 64'h6565_6877), 64'h770d_2c76);

        // Boundary patterns.
        run_one('0, '0, "R1", "R2", "R3", '0, 1'b0, 1'b0);
        run_one('1, '1, "R1", "R2", "R3", '0, 1'b0, 1'b0);

        // Assorted inputs.
        for (int v = 0; v < 5; v++) begin
            run_one({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                    "R1", "R2", "R3", '0, 1'b0, 1'b0);
        end

        // R8: identical input twice, LFSR reseeded each time.
        run_one(64'h0123_4567_89ab_cdef, {32'hdead_beef, 32'h0bad_f00d, 64'h1357_9bdf_2468_ace0},
                "R8", "R8", "R8", '0, 1'b0, 1'b0);
        run_one(64'h0123_4567_89ab_cdef, {32'hdead_beef, 32'h0bad_f00d, 64'h1357_9bdf_2468_ace0},
                "R8", "R8", "R8", '0, 1'b0, 1'b0);

        // R7: start raised mid-run with different data is ignored.
        run_one(64'hfeed_face_cafe_0001, {$urandom, $urandom, $urandom, $urandom},
                "R7", "R7", "R7", '0, 1'b0, 1'b1);

        for (int i = 0; i < 3; i++) begin
            chk("R6", $sformatf("pending results n=%0d", wid[i]), 64'(exp_q[i].size()), 64'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule